// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block is a purely combinational binary adder of parameterised width (32 bits by default). It takes two unsigned operands and a carry-in, and returns the sum and the carry-out. The operand is cut into stages. The first stage is `M` bits wide, and each stage after it is one bit wider than the one before. The last stage is cut short if the growth would run past the word width. Each bit first forms a generate term and a propagate term.

Every stage except the first runs two ripple chains side by side. One chain assumes a carry-in of 0 and the other assumes 1. When the real carry reaches the stage from below, a 2-to-1 selection picks one chain's carries and sum bits. Because the stages widen step by step, each stage's chains finish at about the time the select carry arrives. The first stage sees the true carry-in directly, so it has only one chain.

The block is used wherever a wide single-cycle add must be shorter than a plain ripple. Stage boundaries are computed at elaboration from the width parameters.

Top module: `sqsel_adder`

## Requirements
- R1: `{cout, sum}` equals the unsigned value `a + b + cin`, taken over N+1 bits, for every operand pair and both carry-in values.
- R2: Each bit forms generate = a AND b and propagate = a XOR b. Its sum bit is the propagate term XOR the carry entering that bit.
- R3: Stage k (counted from 0) starts at bit k*M + k*(k-1)/2 and is M+k bits wide. The final stage holds only the bits that remain below N. A carry rippling from bit 0 through every low bit reaches each bit position k, giving sum = 2^k for a = 2^k - 1, b = 0, cin = 1.
- R4: A stage whose operand bits are all zero passes out carry 0 from both chains, whatever its carry-in. So a = b = 0 with cin = 1 gives sum = 1 and cout = 0.
- R5: In each duplicated stage, a carry-out of 1 from the chain that assumes carry-in 0 implies a carry-out of 1 from the chain that assumes carry-in 1.
- R6: In a stage where every bit propagates, the chain that assumes carry-in 0 gives carry-out 0 and the chain that assumes carry-in 1 gives carry-out 1. So all-ones plus 0 with cin = 1 gives sum 0 and cout 1.
- R7: `cout` is the selected carry of the final stage. All-ones plus 1 gives sum 0 and cout 1, and all-ones plus all-ones with cin = 1 gives an all-ones sum and cout 1.
- R8: Defaults are N = 32 and M = 2, which gives stages of 2, 3, 4, 5, 6, 7 and a truncated 5 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
Zero plus zero with both carry-in values separates the kill case from an injected carry. All-ones plus one and all-ones plus zero with carry-in 1 force the carry through every stage's select path, which exposes a wrong mux polarity or a lost final carry. A walking pattern of low-bit ones with carry-in 1 lands the carry on each bit position in turn, so a misplaced stage boundary or a truncation error in the last stage shows up at one specific bit. Random operand pairs with random carry-in then test mixed generate, propagate and kill runs against a behavioural sum.

// File: rtl/sqsel_pkg.sv
package sqsel_pkg;

  // first bit index of stage k
  function automatic int stage_lo(input int m, input int k);
    return k * m + (k * (k - 1)) / 2;
  endfunction

  // width of stage k, trimmed to the word width n
  function automatic int stage_width(input int n, input int m, input int k);
    int lo;
    int w;
    lo = stage_lo(m, k);
    w  = m + k;
    if (lo + w > n) w = n - lo;
    return w;
  endfunction

  // number of stages needed to cover n bits
  function automatic int stage_count(input int n, input int m);
    int acc;
    int s;
    acc = 0;
    s   = 0;
    for (int k = 0; k < n; k++) begin
      if (acc < n) begin
        acc = acc + m + k;
        s   = s + 1;
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/sqsel_pg.sv
module sqsel_pg #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] gen,
  output logic [W-1:0] prop
);
  // R2: per-bit setup before any carry work
  assign gen  = a & b;
  assign prop = a ^ b;
endmodule

// File: rtl/sqsel_ripple.sv
module sqsel_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] gen,
  input  logic [W-1:0] prop,
  input  logic         cin,
  output logic [W-1:0] cbit,   // carry entering each bit
  output logic         cout
);
  logic [W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign chain[i+1] = gen[i] | (prop[i] & chain[i]);
    assign cbit[i]    = chain[i];
  end

  assign cout = chain[W];
endmodule

// File: rtl/sqsel_stage.sv
module sqsel_stage #(
  parameter int W     = 4,
  parameter bit FIRST = 1'b0
) (
  input  logic [W-1:0] gen,
  input  logic [W-1:0] prop,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  if (FIRST) begin : g_single
    logic [W-1:0] cb;
    sqsel_ripple #(.W(W)) u_chain (
      .gen(gen), .prop(prop), .cin(cin), .cbit(cb), .cout(cout)
    );
    assign sum = prop ^ cb;
  end else begin : g_dual
    logic [W-1:0] cb_lo, cb_hi;   // carry vectors, assumed cin 0 / 1
    logic         co_lo, co_hi;   // chain carry-outs brought out for checks
    logic [W-1:0] cb_sel;

    sqsel_ripple #(.W(W)) u_chain0 (
      .gen(gen), .prop(prop), .cin(1'b0), .cbit(cb_lo), .cout(co_lo)
    );
    sqsel_ripple #(.W(W)) u_chain1 (
      .gen(gen), .prop(prop), .cin(1'b1), .cbit(cb_hi), .cout(co_hi)
    );

    // 2-to-1 select of carry vector and carry-out by the arriving carry
    assign cb_sel = cin ? cb_hi : cb_lo;
    assign cout   = cin ? co_hi : co_lo;
    assign sum    = prop ^ cb_sel;

    always_comb begin
      // R5: the carry-in-1 chain dominates the carry-in-0 chain
      a_r5_chain_order: assert (!co_lo || co_hi)
        else $error("R5: chain0 carry set without chain1");
      // R6: full propagate run splits the chains
      a_r6_full_prop: assert (!(&prop) || (!co_lo && co_hi))
        else $error("R6: full propagate stage mis-carried");
      // R4: all-kill stage emits no carry from either chain
      a_r4_all_kill: assert (!((gen | prop) == '0) || (!co_lo && !co_hi))
        else $error("R4: killed stage produced carry");
    end
  end
endmodule

// File: rtl/sqsel_adder.sv
module sqsel_adder #(
  parameter int N = 32,
  parameter int M = 2
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  import sqsel_pkg::*;

  localparam int NSTG = stage_count(N, M);

  logic [N-1:0]  gen, prop;
  logic [NSTG:0] stg_c;   // carry between stages

  sqsel_pg #(.W(N)) u_pg (
    .a(a), .b(b), .gen(gen), .prop(prop)
  );

  assign stg_c[0] = cin;

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    localparam int LO = stage_lo(M, k);
    localparam int SW = stage_width(N, M, k);
    sqsel_stage #(.W(SW), .FIRST(k == 0)) u_stg (
      .gen (gen[LO +: SW]),
      .prop(prop[LO +: SW]),
      .cin (stg_c[k]),
      .sum (sum[LO +: SW]),
      .cout(stg_c[k+1])
    );
  end

  // R7: carry-out is the selected carry of the final stage
  assign cout = stg_c[NSTG];

  always_comb begin
    // R1: whole-word result matches the arithmetic sum
    a_r1_exact_sum: assert ({cout, sum} ==
                            ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin}))
      else $error("R1: adder result mismatch");
  end
endmodule

// File: tb/tb_sqsel_adder.sv
module tb_sqsel_adder;
  localparam int N = 32;

  logic         clk;
  logic [N-1:0] a, b, sum;
  logic         cin, cout;
  int           n_run, n_fail;

  sqsel_adder #(.N(N), .M(2)) dut (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // a, b, cin, expected sum, expected cout
  typedef struct packed {
    logic [N-1:0] va;
    logic [N-1:0] vb;
    logic         vc;
    logic [N-1:0] es;
    logic         ec;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TABLE [NV] = '{
    '{32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0},  // R4 zero
    '{32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_0001, 1'b0},  // R4 kill with cin
    '{32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1},  // R7 ones+1
    '{32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b1},  // R6 propagate run
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b1},  // R7 max
    '{32'h1234_5678, 32'h8765_4321, 1'b0, 32'h9999_9999, 1'b0},  // R2 no carries
    '{32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1},  // R7 top generate
    '{32'h0000_FFFF, 32'h0000_0001, 1'b0, 32'h0001_0000, 1'b0},  // R3 mid boundary
    '{32'h7FFF_FFFF, 32'h0000_0000, 1'b1, 32'h8000_0000, 1'b0},  // R6 into top bit
    '{32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 32'h0000_0000, 1'b1}   // R6 alternating
  };

  task automatic check(input string req, input logic [N-1:0] es, input logic ec);
    n_run++;
    if (sum !== es || cout !== ec) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h cin=%b got sum=%h cout=%b exp sum=%h cout=%b",
               req, a, b, cin, sum, cout, es, ec);
    end
  endtask

  task automatic apply(input logic [N-1:0] va, input logic [N-1:0] vb, input logic vc);
    @(posedge clk);
    a = va; b = vb; cin = vc;
    @(negedge clk);
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    a = '0; b = '0; cin = 1'b0;

    // idle state: zero inputs give zero outputs (R1)
    @(negedge clk);
    check("R1 idle", '0, 1'b0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      apply(TABLE[i].va, TABLE[i].vb, TABLE[i].vc);
      check("R1/R4/R6/R7 table", TABLE[i].es, TABLE[i].ec);
    end

    // R3: carry walks to each bit position across every stage boundary
    for (int k = 1; k <= N; k++) begin
      logic [N:0] full;
      full = {{N{1'b0}}, 1'b1} << k;
      apply(full[N-1:0] - 1'b1 + (k == N ? {N{1'b1}} + 1'b1 : '0), '0, 1'b1);
      check("R3 walk", full[N-1:0], full[N]);
    end

    // R2: single-bit generate at each position lands one bit higher
    for (int k = 0; k < N; k++) begin
      logic [N:0] exp2;
      exp2 = {{N{1'b0}}, 1'b1} << (k + 1);
      apply({{(N-1){1'b0}}, 1'b1} << k, {{(N-1){1'b0}}, 1'b1} << k, 1'b0);
      check("R2 generate", exp2[N-1:0], exp2[N]);
    end

    // R1/R5: random operands, behavioural reference
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] ra, rb;
      logic         rc;
      logic [N:0]   ref_v;
      ra = $urandom; rb = $urandom; rc = 1'($urandom);
      if (i % 4 == 1) rb = ~ra;   // long propagate runs (R5/R6)
      ref_v = {1'b0, ra} + {1'b0, rb} + {{N{1'b0}}, rc};
      apply(ra, rb, rc);
      check("R1/R5 random", ref_v[N-1:0], ref_v[N]);
    end

    // R8: default width of 32 bits, carry out of bit 31
    apply(32'h8000_0000, 32'h7FFF_FFFF, 1'b1);
    check("R8 width", 32'h0000_0000, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule